// File: doc/BRIEF.md
# Addressable Scan Cell Array

This block holds a bank of scan cells that are reached one at a time by address, the way words of a memory are. It replaces a shift chain. A tester loads a cell address bit by bit into a small address register, which runs on its own address clock. A decoder turns the address into a one-hot select line for each cell. While test mode is on, a system clock edge writes the shared serial data input into the selected cell only, and no other cell moves. The selected cell's state can be read at any time on a single serial output pin.

When test mode is off, every cell captures its own functional input from the surrounding logic on the system clock. This is the block's normal mission behaviour. A tester can therefore capture a functional response, change a single cell by address, and capture again. This gives a single-input-change pattern without any shifting through the other cells.

Top module: `ras_array`

## Requirements
- R1: While reset is low, all cells and the address register are cleared. After reset, the cell outputs read all zeros and the serial output reads 0.
- R2: The address register shifts on each rising edge of the address clock. The new bit enters at the least significant end, so an address is loaded most significant bit first. Only the last ADDR_W bits shifted in are kept. Shifting the address never changes any cell.
- R3: The decoder raises at most one select line, the one whose index equals the address. An address of NUM_CELLS or above raises none.
- R4: When test mode is high, the selected cell takes the serial data input on the rising edge of the system clock.
- R5: When test mode is high, every cell that is not selected keeps its state across the system clock edge.
- R6: The serial output combinationally shows the state of the cell at the current address. For an out-of-range address it shows 0.
- R7: When test mode is low, every cell loads its own bit of the functional input on the rising edge of the system clock.
- R8: A test-mode write while the address is out of range changes no cell.
- R9: Take a functional capture, then one test-mode write that flips the addressed cell. The cell outputs then differ from the captured value in exactly one bit, and the next functional capture replaces all cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; cells update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_clk | input | 1 | Address register clock |
| addr_sdi | input | 1 | Serial address bit, most significant first |
| test_mode | input | 1 | 1: addressed scan write, 0: functional capture |
| scan_in | input | 1 | Shared serial data for the addressed cell |
| func_d | input | NUM_CELLS | Functional next-state inputs, one per cell |
| q | output | NUM_CELLS | Cell states driven to the logic |
| scan_out | output | 1 | State of the addressed cell |

## Verification
Two things can happen in the same system clock edge with test mode high: the addressed cell loads new data, and the serial output goes on reflecting that cell. The bench makes both happen in one edge. It writes the inverse of the cell's current value, then checks at mid-cycle that both the cell output bit and the serial output moved to the new value, while all other bits match a bench-side model. The address clock and the system clock are the other pair that could collide. The bench stops the system clock while it shifts an address. It then judges at the ports that the cell outputs are unchanged and that the serial output follows the new address at once.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        CELL_CAPTURE = 2'd0,
        CELL_LOAD    = 2'd1,
        CELL_KEEP    = 2'd2
    } cell_op_e;

    // choose what one cell does on the next system clock edge
    function automatic cell_op_e pick_op(input logic test_en, input logic selected);
        if (!test_en) begin
            return CELL_CAPTURE;
        end
        if (selected) begin
            return CELL_LOAD;
        end
        return CELL_KEEP;
    endfunction

endpackage

// File: rtl/ras_addr_sreg.sv
module ras_addr_sreg #(
    parameter int ADDR_W = 4
) (
    input  logic              addr_clk,
    input  logic              rst_n,
    input  logic              sdi,
    output logic [ADDR_W-1:0] addr
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } sreg_t;

    sreg_t state_d;
    sreg_t state_q;

    always_comb begin
        state_d      = state_q;
        state_d.addr = {state_q.addr[ADDR_W-2:0], sdi};
    end

    always_ff @(posedge addr_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign addr = state_q.addr;

endmodule

// File: rtl/ras_addr_decode.sv
module ras_addr_decode #(
    parameter int NUM_CELLS = 12,
    parameter int ADDR_W    = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_CELLS-1:0] sel
);

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_line
        assign sel[i] = (addr == ADDR_W'(i));
    end

endmodule

// File: rtl/ras_cell_bank.sv
module ras_cell_bank
    import ras_pkg::*;
#(
    parameter int NUM_CELLS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 test_en,
    input  logic                 scan_in,
    input  logic [NUM_CELLS-1:0] sel,
    input  logic [NUM_CELLS-1:0] func_d,
    output logic [NUM_CELLS-1:0] q
);

    typedef struct packed {
        logic [NUM_CELLS-1:0] bits;
    } bank_t;

    bank_t bank_d;
    bank_t bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_CELLS; i++) begin
            unique case (pick_op(test_en, sel[i]))
                CELL_CAPTURE: bank_d.bits[i] = func_d[i];
                CELL_LOAD:    bank_d.bits[i] = scan_in;
                default:      bank_d.bits[i] = bank_q.bits[i];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign q = bank_q.bits;

endmodule

// File: rtl/ras_readout.sv
module ras_readout #(
    parameter int NUM_CELLS = 12
) (
    input  logic [NUM_CELLS-1:0] q,
    input  logic [NUM_CELLS-1:0] sel,
    output logic                 scan_out
);

    // select is one-hot or empty, so an AND-OR tree is the mux
    assign scan_out = |(q & sel);

endmodule

// File: rtl/ras_array.sv
module ras_array #(
    parameter int NUM_CELLS = 12,
    parameter int ADDR_W    = $clog2(NUM_CELLS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 addr_clk,
    input  logic                 addr_sdi,
    input  logic                 test_mode,
    input  logic                 scan_in,
    input  logic [NUM_CELLS-1:0] func_d,
    output logic [NUM_CELLS-1:0] q,
    output logic                 scan_out
);

    logic [ADDR_W-1:0]    addr;
    logic [NUM_CELLS-1:0] sel;

    ras_addr_sreg #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .addr_clk (addr_clk),
        .rst_n    (rst_n),
        .sdi      (addr_sdi),
        .addr     (addr)
    );

    ras_addr_decode #(
        .NUM_CELLS (NUM_CELLS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    ras_cell_bank #(
        .NUM_CELLS (NUM_CELLS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .test_en (test_mode),
        .scan_in (scan_in),
        .sel     (sel),
        .func_d  (func_d),
        .q       (q)
    );

    ras_readout #(
        .NUM_CELLS (NUM_CELLS)
    ) u_out (
        .q        (q),
        .sel      (sel),
        .scan_out (scan_out)
    );

endmodule

// File: rtl/ras_array_chk.sv
module ras_array_chk #(
    parameter int NUM_CELLS = 12,
    parameter int ADDR_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 test_mode,
    input logic                 scan_in,
    input logic [NUM_CELLS-1:0] func_d,
    input logic [NUM_CELLS-1:0] q,
    input logic [NUM_CELLS-1:0] sel,
    input logic [ADDR_W-1:0]    addr,
    input logic                 scan_out
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_CELLS);

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R3
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, addr} >= LIMIT) |-> (sel == '0));

    // R4
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> ((q & $past(sel)) == ($past(sel) & {NUM_CELLS{$past(scan_in)}})));

    // R5
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> ((q & ~$past(sel)) == ($past(q) & ~$past(sel))));

    // R7
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> (q == $past(func_d)));

    // R6
    readout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_out == |(q & (NUM_CELLS'(1) << addr)));

endmodule

bind ras_array ras_array_chk #(
    .NUM_CELLS (NUM_CELLS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .scan_in   (scan_in),
    .func_d    (func_d),
    .q         (q),
    .sel       (sel),
    .addr      (addr),
    .scan_out  (scan_out)
);

// File: tb/test_ras_array.sv
module test_ras_array;

    localparam int N = 12;
    localparam int AW = 4;

    logic         clk = 1'b0;
    logic         clk_en = 1'b1;
    logic         rst_n = 1'b0;
    logic         addr_clk = 1'b0;
    logic         addr_sdi = 1'b0;
    logic         test_mode = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] func_d = '0;
    logic [N-1:0] q;
    logic         scan_out;

    logic [N-1:0] model = '0;
    int           cur_addr = 0;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    ras_array #(.NUM_CELLS(N), .ADDR_W(AW)) i_ras_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_clk  (addr_clk),
        .addr_sdi  (addr_sdi),
        .test_mode (test_mode),
        .scan_in   (scan_in),
        .func_d    (func_d),
        .q         (q),
        .scan_out  (scan_out)
    );

    // 50 MHz, stoppable in the low phase
    always begin
        #10;
        if (clk_en) clk = ~clk;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        #5;
    endtask

    function automatic logic exp_out();
        return (cur_addr < N) ? model[cur_addr] : 1'b0;
    endfunction

    // shift nbits of val, msb first, with the system clock halted
    task automatic shift_addr(input int val, input int nbits);
        @(negedge clk);
        clk_en = 1'b0;
        for (int b = nbits - 1; b >= 0; b--) begin
            addr_sdi = val[b];
            #2 addr_clk = 1'b1;
            #3 addr_clk = 1'b0;
        end
        cur_addr = val & ((1 << AW) - 1);
        #1;
    endtask

    task automatic resume();
        clk_en = 1'b1;
    endtask

    task automatic t_reset();
        check(q == '0, "R1 cells", int'(q), 0);
        check(scan_out == 1'b0, "R1 scan_out", int'(scan_out), 0);
    endtask

    task automatic t_capture(input logic [N-1:0] v);
        test_mode = 1'b0;
        func_d = v;
        cycle();
        model = v;
        check(q == model, "R7 capture", int'(q), int'(model));
    endtask

    task automatic t_addr_quiet();
        // R2: long shift, only last AW bits kept; cells untouched
        shift_addr(12'hF05, 12);
        check(q == model, "R2 cells untouched", int'(q), int'(model));
        check(scan_out == exp_out(), "R6 follows address", int'(scan_out), int'(exp_out()));
        resume();
    endtask

    task automatic t_walk();
        for (int a = 0; a < N; a++) begin
            shift_addr(a, AW);
            check(scan_out == exp_out(), "R6 read before write", int'(scan_out), int'(exp_out()));
            resume();
            test_mode = 1'b1;
            scan_in = ~model[a];
            func_d = ~model;
            cycle();
            model[a] = scan_in;
            check(q == model, "R4 R5 addressed write", int'(q), int'(model));
            check(scan_out == model[a], "R6 shows new value", int'(scan_out), int'(model[a]));
        end
    endtask

    task automatic t_out_of_range(input int a);
        shift_addr(a, AW);
        check(scan_out == 1'b0, "R6 R3 out of range reads 0", int'(scan_out), 0);
        resume();
        test_mode = 1'b1;
        scan_in = 1'b1;
        cycle();
        scan_in = 1'b0;
        cycle();
        check(q == model, "R8 out of range write", int'(q), int'(model));
    endtask

    task automatic t_single_change(input logic [N-1:0] v1, input logic [N-1:0] v2, input int a);
        logic [N-1:0] snap;
        t_capture(v1);
        snap = q;
        shift_addr(a, AW);
        resume();
        test_mode = 1'b1;
        scan_in = ~v1[a];
        cycle();
        check($countones(q ^ snap) == 1, "R9 one bit changed", $countones(q ^ snap), 1);
        check(q[a] != snap[a], "R9 changed bit is addressed", int'(q[a]), int'(~snap[a]));
        model = q;
        t_capture(v2);
        check(q == v2, "R9 next capture", int'(q), int'(v2));
    endtask

    initial begin
        #95;
        t_reset();
        rst_n = 1'b1;
        cycle();
        t_reset();
        t_capture(12'hA5C);
        t_capture(12'h3B1);
        t_addr_quiet();
        t_walk();
        t_out_of_range(13);
        t_out_of_range(15);
        t_single_change(12'h0F0, 12'h9C3, 7);
        t_single_change(12'hFFF, 12'h000, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule